// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the target side of a three-wire serial EEPROM. It lives in a single system clock domain. It samples a select line, a serial clock and a serial data line, then decodes instructions framed by a start bit. Each instruction carries a two-bit opcode, an address and, for programming commands, a data field. The block holds its own register-based array, a write-enable latch, a sequential read pointer and a busy timer. The busy timer stands in for the self-timed programming interval.

An organisation input selects the access mode. In word mode the array appears as 64 locations of 16 bits. In byte mode it appears as 128 locations of 8 bits. Reads stream out one leading zero and then data with the most significant bit first, and they continue through consecutive locations while select stays high. Programming commands take effect when select falls. After that, raising select shows a ready/busy flag on the serial output.

Top module: `mw_eeprom_target`

## Requirements
- R1: While select is high and no instruction is in progress, each serial clock rising edge that samples data 0 is ignored. The first rising edge that samples 1 is the start bit, and the next two rising edges carry the opcode, first bit as the more significant one.
- R2: Opcode 10 reads, 01 writes one location and 11 erases one location. For opcode 00, the two most significant address bits select the sub-command: 11 enables programming, 00 disables it, 10 erases the whole array and 01 writes the data field to every location. The other address bits are ignored.
- R3: The organisation input is sampled at the start bit. When high it gives a 6-bit address and a 16-bit data field. When low it gives a 7-bit address and an 8-bit data field. All fields are sent most significant bit first.
- R4: On a read, the serial output is 0 from the rising clock edge that samples the last address bit. Each following rising edge presents the next data bit, most significant first.
- R5: While select stays high, a read continues into the next location with no zero bit in between. The location after the highest address (63 in word mode, 127 in byte mode) is location 0.
- R6: A single write or a write-all starts only if select falls after the last data bit is sampled and before the next rising clock edge. If select falls earlier, or if a further rising edge comes first, nothing is programmed.
- R7: After reset the enable latch is clear and every location reads all ones. While the latch is clear, write and erase commands have no effect. Reads work whatever the latch state.
- R8: A single erase sets the addressed location to all ones. Erase-all sets every location to all ones. Write-all stores its data field in every location. All of them start when select falls after the address (or data) is complete.
- R9: Once a programming cycle has started, the serial output is 0 while select is high for PROG_CYCLES system clocks and 1 after that. Any start bit sent during that interval is ignored.
- R10: The serial output is 1 whenever select is low. Select falling in the middle of an instruction drops it without any effect, and the next instruction begins with a new start bit.
- R11: In byte mode, byte address b is stored in word b/2. An odd b uses bits 15:8 of that word and an even b uses bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Select, active high |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in, sampled on serial clock rising edges |
| org_word_i | input | 1 | Organisation: 1 gives 16-bit words, 0 gives bytes |
| sdo_o | output | 1 | Serial data out and ready/busy flag |

## Verification
The assertions assume that select, serial clock and data each stay stable for several system clocks. They also assume that select never changes in the same synchronised cycle as a rising serial clock edge. The bench respects this by holding each serial clock phase for four system clocks, changing data only while the clock is low, and moving select only while the clock is low. The organisation input changes only while select is low.

// File: rtl/mw_pkg.sv
package mw_pkg;

    // Decoder states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_WAIT,
        ST_DEAD
    } mw_state_e;

    // Array operations, also used to remember a command waiting for select to fall
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_ERASE,
        CMD_WRALL,
        CMD_ERALL
    } mw_cmd_e;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o
);

    logic [N-1:0] stage_q [STAGES];
    logic [N-1:0] stage_d [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = raw_i;
        end else begin : g_next
            always_comb stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign lvl_o = stage_q[STAGES-1];

endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R9: a started cycle is reported busy on the next clock
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

endmodule

// File: rtl/mw_array.sv
module mw_array import mw_pkg::*; #(
    parameter int WORDS = 64,
    parameter int WW    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  mw_cmd_e                      op_i,
    input  logic [$clog2(WORDS):0]       op_addr_i,
    input  logic [WW-1:0]                op_data_i,
    input  logic                         op_byte_i,
    input  logic [$clog2(WORDS):0]       rd_addr_i,
    input  logic                         rd_byte_i,
    output logic [WW-1:0]                rd_data_o
);

    localparam int WAW = $clog2(WORDS);
    localparam int BAW = WAW + 1;
    localparam int HW  = WW / 2;

    logic [WORDS*WW-1:0] flat;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [WW-1:0] word_q, word_d;
        logic          hit;

        always_comb begin
            hit    = ((op_byte_i ? op_addr_i[BAW-1:1] : op_addr_i[WAW-1:0]) == WAW'(g));
            word_d = word_q;
            case (op_i)
                CMD_WRALL: word_d = op_byte_i ? {op_data_i[HW-1:0], op_data_i[HW-1:0]} : op_data_i;
                CMD_ERALL: word_d = '1;
                CMD_WRITE: begin
                    if (hit) begin
                        if (!op_byte_i)      word_d = op_data_i;
                        else if (op_addr_i[0]) word_d[WW-1:HW] = op_data_i[HW-1:0];
                        else                 word_d[HW-1:0] = op_data_i[HW-1:0];
                    end
                end
                CMD_ERASE: begin
                    if (hit) begin
                        if (!op_byte_i)      word_d = '1;
                        else if (op_addr_i[0]) word_d[WW-1:HW] = '1;
                        else                 word_d[HW-1:0] = '1;
                    end
                end
                default: ;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '1;
            else        word_q <= word_d;
        end

        assign flat[g*WW +: WW] = word_q;
    end

    // Read port, result left-aligned so the shifter always uses the top bit
    logic [WAW-1:0] rd_idx;
    logic [WW-1:0]  rd_word;

    always_comb begin
        rd_idx  = rd_byte_i ? rd_addr_i[BAW-1:1] : rd_addr_i[WAW-1:0];
        rd_word = flat[rd_idx*WW +: WW];
        if (!rd_byte_i)
            rd_data_o = rd_word;
        else if (rd_addr_i[0])
            rd_data_o = {rd_word[WW-1:HW], {HW{1'b0}}};
        else
            rd_data_o = {rd_word[HW-1:0], {HW{1'b0}}};
    end

    // R8: contents only move when an operation is issued
    a_r8_hold_without_op: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CMD_NONE) |=> $stable(flat));

endmodule

// File: rtl/mw_eeprom_target.sv
module mw_eeprom_target import mw_pkg::*; #(
    parameter int WORDS       = 64,
    parameter int WW          = 16,
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic org_word_i,
    output logic sdo_o
);

    localparam int WAW  = $clog2(WORDS);
    localparam int BAW  = WAW + 1;
    localparam int HW   = WW / 2;
    localparam int CNTW = $clog2(WW + BAW + 1);

    typedef struct packed {
        mw_state_e       st;
        logic [1:0]      opc;
        logic [BAW-1:0]  addr;
        logic [WW-1:0]   data;
        logic [CNTW-1:0] cnt;
        logic [WW-1:0]   shreg;
        logic            rd_out;
        logic            wen;
        logic            status;
        logic            byte_m;
        mw_cmd_e         pend;
        logic            s_prev;
        logic            c_prev;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    // Synchronised inputs: bit 0 select, bit 1 clock, bit 2 data
    logic [2:0] sync_lvl;
    logic       s_lvl, c_lvl, d_lvl, c_rise, s_fall;

    mw_sync #(.N(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({sdi_i, sclk_i, sel_i}),
        .lvl_o (sync_lvl)
    );

    assign s_lvl  = sync_lvl[0];
    assign c_lvl  = sync_lvl[1];
    assign d_lvl  = sync_lvl[2];
    assign c_rise = c_lvl & ~ctl_q.c_prev;
    assign s_fall = ~s_lvl & ctl_q.s_prev;

    logic            busy;
    logic            prog_start;
    mw_cmd_e         arr_op;
    logic [BAW-1:0]  rd_addr;
    logic [WW-1:0]   rd_data;

    mw_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (busy)
    );

    mw_array #(.WORDS(WORDS), .WW(WW)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (arr_op),
        .op_addr_i (ctl_q.addr),
        .op_data_i (ctl_q.data),
        .op_byte_i (ctl_q.byte_m),
        .rd_addr_i (rd_addr),
        .rd_byte_i (ctl_q.byte_m),
        .rd_data_o (rd_data)
    );

    // Read address: next location while streaming, else the address being completed
    always_comb begin
        if (ctl_q.st == ST_READ)
            rd_addr = ctl_q.byte_m ? ctl_q.addr + BAW'(1)
                                   : {1'b0, ctl_q.addr[WAW-1:0] + WAW'(1)};
        else
            rd_addr = {ctl_q.addr[BAW-2:0], d_lvl};
    end

    logic [CNTW-1:0] a_last, d_last;
    logic [BAW-1:0]  a_full;
    logic [1:0]      sub_cmd;

    always_comb begin
        a_last  = ctl_q.byte_m ? CNTW'(BAW - 1) : CNTW'(WAW - 1);
        d_last  = ctl_q.byte_m ? CNTW'(HW - 1)  : CNTW'(WW - 1);
        a_full  = {ctl_q.addr[BAW-2:0], d_lvl};
        sub_cmd = ctl_q.byte_m ? a_full[BAW-1:BAW-2] : a_full[WAW-1:WAW-2];
    end

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.s_prev = s_lvl;
        ctl_d.c_prev = c_lvl;
        arr_op       = CMD_NONE;
        prog_start   = 1'b0;

        if (!s_lvl) begin
            if (s_fall && ctl_q.st == ST_WAIT && ctl_q.pend != CMD_NONE
                && ctl_q.wen && !busy) begin
                arr_op       = ctl_q.pend;
                prog_start   = 1'b1;
                ctl_d.status = 1'b1;
            end
            ctl_d.st   = ST_IDLE;
            ctl_d.pend = CMD_NONE;
        end else if (c_rise) begin
            case (ctl_q.st)
                ST_IDLE: begin
                    if (d_lvl && !busy) begin
                        ctl_d.st     = ST_OP;
                        ctl_d.cnt    = '0;
                        ctl_d.status = 1'b0;
                        ctl_d.byte_m = ~org_word_i;
                        ctl_d.addr   = '0;
                        ctl_d.data   = '0;
                    end
                end
                ST_OP: begin
                    ctl_d.opc = {ctl_q.opc[0], d_lvl};
                    if (ctl_q.cnt == CNTW'(1)) begin
                        ctl_d.st  = ST_ADDR;
                        ctl_d.cnt = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + CNTW'(1);
                    end
                end
                ST_ADDR: begin
                    ctl_d.addr = a_full;
                    ctl_d.cnt  = ctl_q.cnt + CNTW'(1);
                    if (ctl_q.cnt == a_last) begin
                        ctl_d.cnt = '0;
                        case (ctl_q.opc)
                            2'b10: begin
                                ctl_d.st     = ST_READ;
                                ctl_d.rd_out = 1'b0;
                                ctl_d.shreg  = rd_data;
                            end
                            2'b01: begin
                                ctl_d.st   = ST_DATA;
                                ctl_d.pend = CMD_WRITE;
                            end
                            2'b11: begin
                                ctl_d.st   = ST_WAIT;
                                ctl_d.pend = CMD_ERASE;
                            end
                            default: begin
                                case (sub_cmd)
                                    2'b11: begin
                                        ctl_d.wen = 1'b1;
                                        ctl_d.st  = ST_DEAD;
                                    end
                                    2'b00: begin
                                        ctl_d.wen = 1'b0;
                                        ctl_d.st  = ST_DEAD;
                                    end
                                    2'b10: begin
                                        ctl_d.st   = ST_WAIT;
                                        ctl_d.pend = CMD_ERALL;
                                    end
                                    default: begin
                                        ctl_d.st   = ST_DATA;
                                        ctl_d.pend = CMD_WRALL;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    ctl_d.data = {ctl_q.data[WW-2:0], d_lvl};
                    ctl_d.cnt  = ctl_q.cnt + CNTW'(1);
                    if (ctl_q.cnt == d_last)
                        ctl_d.st = ST_WAIT;
                end
                ST_READ: begin
                    ctl_d.rd_out = ctl_q.shreg[WW-1];
                    if (ctl_q.cnt == d_last) begin
                        ctl_d.cnt   = '0;
                        ctl_d.addr  = rd_addr;
                        ctl_d.shreg = rd_data;
                    end else begin
                        ctl_d.cnt   = ctl_q.cnt + CNTW'(1);
                        ctl_d.shreg = {ctl_q.shreg[WW-2:0], 1'b0};
                    end
                end
                ST_WAIT: begin
                    // a data-carrying command loses its window on a further clock
                    if (ctl_q.pend == CMD_WRITE || ctl_q.pend == CMD_WRALL) begin
                        ctl_d.st   = ST_DEAD;
                        ctl_d.pend = CMD_NONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        if (!s_lvl)
            sdo_o = 1'b1;
        else if (ctl_q.st == ST_READ)
            sdo_o = ctl_q.rd_out;
        else if (ctl_q.status && ctl_q.st == ST_IDLE)
            sdo_o = ~busy;
        else
            sdo_o = 1'b1;
    end

    logic rd_active;
    assign rd_active = (ctl_q.st == ST_READ);

    // R4: the first bit of every read burst is a zero
    a_r4_dummy_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_active) |-> !ctl_q.rd_out);

    // R7: with the latch clear no programming cycle can begin
    a_r7_no_prog_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.wen |=> !$rose(busy));

    // R9: the decoder stays idle while a cycle runs
    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_q.st == ST_IDLE) |=> (ctl_q.st == ST_IDLE));

endmodule

// File: tb/tb_mw_eeprom_target.sv
module tb_mw_eeprom_target;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int PROG       = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b1;
    logic sdo;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [15:0] ref_mem [64];
    bit          ref_wen;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_target #(.PROG_CYCLES(PROG)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel),
        .sclk_i     (sclk),
        .sdi_i      (sdi),
        .org_word_i (org),
        .sdo_o      (sdo)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int aw();  return org ? 6 : 7;  endfunction
    function automatic int dw();  return org ? 16 : 8; endfunction

    function automatic logic [15:0] ref_get(input int a);
        int b;
        if (org) return ref_mem[a % 64];
        b = a % 128;
        return (b % 2 == 1) ? {8'h00, ref_mem[b/2][15:8]} : {8'h00, ref_mem[b/2][7:0]};
    endfunction

    task automatic ref_put(input int a, input logic [15:0] v);
        if (org) ref_mem[a % 64] = v;
        else if (a % 2 == 1) ref_mem[(a % 128)/2][15:8] = v[7:0];
        else ref_mem[(a % 128)/2][7:0] = v[7:0];
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sel_up;   sel = 1'b1; wait_clk(HALF); endtask
    task automatic sel_down; sel = 1'b0; wait_clk(HALF); endtask

    // one serial bit: Q is sampled at the end of the low phase, just before the rise
    task automatic bit_io(input logic b, output logic q);
        sdi = b;
        wait_clk(HALF);
        q = sdo;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic q;
        for (int i = n - 1; i >= 0; i--) bit_io(v[i], q);
    endtask

    task automatic do_read(input string req, input int a, input int nwords, input int lead);
        logic q;
        logic [15:0] w;
        sel_up;
        send(0, lead);
        send(3'b110, 3);
        send(a, aw());
        bit_io(1'b0, q);
        check({req, " dummy zero (R4)"}, q, 0);
        for (int k = 0; k < nwords; k++) begin
            w = '0;
            for (int i = 0; i < dw(); i++) begin
                bit_io(1'b0, q);
                w = {w[14:0], q};
            end
            check(req, w, ref_get(a + k));
        end
        sel_down;
    endtask

    task automatic do_write(input int a, input logic [15:0] v, input bit late);
        logic q;
        sel_up;
        send(3'b101, 3);
        send(a, aw());
        send(v, dw());
        if (late) bit_io(1'b0, q);
        sel_down;
        if (!late && ref_wen) ref_put(a, v);
    endtask

    task automatic do_erase(input int a);
        sel_up;
        send(3'b111, 3);
        send(a, aw());
        sel_down;
        if (ref_wen) ref_put(a, 16'hFFFF);
    endtask

    task automatic do_special(input logic [1:0] sub, input logic [15:0] v);
        sel_up;
        send(3'b100, 3);
        send(32'(sub) << (aw() - 2), aw());
        if (sub == 2'b01) send(v, dw());
        sel_down;
        case (sub)
            2'b11: ref_wen = 1;
            2'b00: ref_wen = 0;
            2'b10: if (ref_wen) for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
            default: if (ref_wen)
                for (int i = 0; i < 64; i++) ref_mem[i] = org ? v : {v[7:0], v[7:0]};
        endcase
    endtask

    task automatic check_status(input string req, input bit exp_busy, input bit chk_len);
        int waited = 0;
        sel_up;
        check({req, " status"}, sdo, exp_busy ? 0 : 1);
        if (exp_busy) begin
            while (sdo !== 1'b1 && waited < 4*PROG) begin
                wait_clk(1);
                waited++;
            end
            check({req, " ready"}, sdo, 1);
            if (chk_len)
                check({req, " busy length"}, (waited >= PROG - 30 && waited <= PROG) ? 1 : 0, 1);
        end
        sel_down;
    endtask

    initial begin
        logic q;
        for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
        ref_wen = 0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        check("R10 output high after reset", sdo, 1);
        do_read("R7 reset contents", 0, 1, 0);

        // write while disabled
        do_write(3, 16'h1234, 0);
        check_status("R7 disabled write", 0, 0);
        do_read("R7 disabled write no effect, read allowed", 3, 1, 0);

        // enable, then a timed write
        do_special(2'b11, 0);
        do_write(3, 16'h1234, 0);
        check_status("R9 write cycle", 1, 1);
        do_read("R1 R2 read after leading zeros", 3, 1, 3);

        // wrap of a word burst
        do_write(63, 16'hBEEF, 0);
        check_status("R9 write top", 1, 0);
        do_write(0, 16'h0F0F, 0);
        check_status("R9 write zero", 1, 0);
        do_read("R5 word burst wraps", 62, 4, 0);

        // write whose select falls one clock late
        do_write(3, 16'h0000, 1);
        check_status("R6 late select", 0, 0);
        do_read("R6 late select leaves location", 3, 1, 0);

        // single erase
        do_erase(3);
        check_status("R8 erase cycle", 1, 0);
        do_read("R8 erase to ones", 3, 1, 0);

        // write-all
        do_special(2'b01, 16'hA5C3);
        check_status("R8 write-all cycle", 1, 0);
        do_read("R8 write-all fills", 10, 2, 0);

        // instruction during busy is dropped
        do_write(6, 16'h1111, 0);
        check_status("R9 write six", 1, 0);
        do_write(7, 16'h2222, 0);
        sel_up;
        send(3'b111, 3);
        send(6, aw());
        sel_down;
        check_status("R9 busy while erase ignored", 1, 0);
        do_read("R9 erase during busy ignored", 6, 2, 0);

        // abort in the middle of a write
        sel_up;
        send(3'b101, 3);
        send(9, aw());
        send(4'hA, 4);
        sel = 1'b0;
        wait_clk(HALF);
        check("R10 output high with select low", sdo, 1);
        check_status("R10 aborted write", 0, 0);
        do_read("R10 aborted write no effect", 9, 1, 0);

        // byte organisation
        org = 1'b0;
        do_write(13, 16'h0077, 0);
        check_status("R3 byte write", 1, 0);
        do_write(12, 16'h0031, 0);
        check_status("R3 byte write even", 1, 0);
        do_read("R3 R11 byte burst", 12, 2, 0);
        do_write(127, 16'h0055, 0);
        check_status("R3 byte write top", 1, 0);
        do_read("R5 byte burst wraps", 127, 2, 0);
        do_erase(13);
        check_status("R8 byte erase", 1, 0);
        org = 1'b1;
        do_read("R11 byte halves in word", 6, 1, 0);

        // erase-all, then disable
        do_special(2'b10, 0);
        check_status("R8 erase-all cycle", 1, 0);
        do_read("R8 erase-all ones", 62, 3, 0);
        do_write(20, 16'h4444, 0);
        check_status("R9 write twenty", 1, 0);
        do_special(2'b00, 0);
        do_write(20, 16'h9999, 0);
        check_status("R7 write after disable", 0, 0);
        do_erase(20);
        check_status("R7 erase after disable", 0, 0);
        do_read("R2 R7 disable keeps data", 20, 1, 0);

        bit_io(1'b0, q);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule